// File: doc/BRIEF.md
# Vector Element Permute and Shuffle Unit

This block rearranges the elements of 128-bit vectors. Each request carries two source vectors (A and B), the current destination vector D, a 32-bit scalar index and a 2-bit format code that sets the element width. The operation code picks one of nine rearrangements:

- broadcast of one element
- byte slide within fixed-size slices
- even or odd packing
- left, right, even or odd interleaving
- table shuffle steered by control values held in D

Every output element is computed from the values the inputs had before the operation. D is both a data input and a control input, so writing the result over it never disturbs the calculation.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream through a single register stage. A request is taken on a cycle with `in_valid` and `in_ready` both high. Its result appears on `out_vec` with `out_valid` high on the next cycle. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and `out_valid` hold, and no new request is taken. The register file and instruction decode sit outside the block.

Top module: `vperm_unit`

## Requirements
- R1: A request accepted at a clock edge (in_valid and in_ready high) produces out_valid high after that edge, with its result on out_vec. in_ready is high whenever out_valid is low or out_ready is high.
- R2: While out_valid is high and out_ready is low, out_valid stays high, out_vec holds its value and in_ready is low.
- R3: While reset (rst_n low) is applied, out_valid is low and in_ready is high.
- R4: Operation code 0 (broadcast) copies element n of A into every result element, where n is the index modulo the element count.
- R5: Operation code 1 (slide) works on slices. A slice has as many bytes as the format has elements, and slice s covers bytes s·N to s·N+N−1. Inside a slice, the bytes of A (low) are joined to the bytes of D (high), and the result slice is the N-byte run starting at offset n = index mod N.
- R6: Operation code 2 (pack even) places the even-numbered elements of B, in order, in the lower half of the result and those of A in the upper half. Operation code 3 (pack odd) does the same with the odd-numbered elements.
- R7: Operation code 4 (interleave left) sets result element 2i to B's element N/2+i and element 2i+1 to A's element N/2+i. Operation code 5 (interleave right) does the same with element i of each source.
- R8: Operation code 6 (interleave even) sets result element 2i to B's element 2i and element 2i+1 to A's element 2i. Operation code 7 (interleave odd) does the same with element 2i+1 of each source.
- R9: Operation code 8 (shuffle) uses D's element e as a control value. It forms k as bits 5:0 of that control modulo 2N, ignoring all control bits above bit 7. Result element e is B's element k when k < N, and A's element k−N otherwise.
- R10: In the shuffle, a control value with bit 6 or bit 7 set gives a zero result element.
- R11: Operation codes 9 to 15 give an all-zero result.
- R12: Format code 0, 1, 2 and 3 select 8-, 16-, 32- and 64-bit elements (N = 16, 8, 4, 2). Element i occupies bits i·W to i·W+W−1, so element 0 is the least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| op | input | 4 | Operation code (0 to 8 defined) |
| fmt | input | 2 | Element format code |
| src_a | input | 128 | First source vector A |
| src_b | input | 128 | Second source vector B |
| dst_in | input | 128 | Current destination vector D (data for slide, controls for shuffle) |
| index | input | 32 | Scalar index for broadcast and slide |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_vec | output | 128 | New destination vector |

## Verification
The bench sends index values far above the element count, so a design that skips the modulo would pick the wrong element or slide past the slice. Slide is run in every format: a design that uses one 16-byte window for every format, or that takes the high half from B instead of D, gives mixed-up bytes in the upper slices. Shuffle controls mix bit 6, bit 7 and bits above bit 7 in wide elements. A design that tests only bit 7, or that uses the full control word to pick an element, outputs a stray element where a zero belongs or picks the wrong one. A stall test holds out_ready low while a second request waits, which exposes a register that is overwritten under back-pressure or a request that is dropped.

// File: rtl/vperm_pkg.sv
`timescale 1ns/1ps
package vperm_pkg;
  localparam int VEC_W     = 128;
  localparam int FMT_W     = 2;
  localparam int IDX_W     = 32;
  localparam int OP_W      = 4;
  localparam int BASE_EW   = 8;

  typedef enum logic [OP_W-1:0] {
    PERM_SPLAT     = 4'd0,
    PERM_SLIDE     = 4'd1,
    PERM_PACK_EV   = 4'd2,
    PERM_PACK_OD   = 4'd3,
    PERM_ILV_LEFT  = 4'd4,
    PERM_ILV_RIGHT = 4'd5,
    PERM_ILV_EVEN  = 4'd6,
    PERM_ILV_ODD   = 4'd7,
    PERM_SHUFFLE   = 4'd8
  } perm_op_e;
endpackage

// File: rtl/vperm_fmt_engine.sv
`timescale 1ns/1ps
// All permutations for one element width; purely combinational.
module vperm_fmt_engine
  import vperm_pkg::*;
#(
  parameter int VEC_BITS = VEC_W,
  parameter int EW       = BASE_EW
) (
  input  logic [OP_W-1:0]     op,
  input  logic [VEC_BITS-1:0] src_a,
  input  logic [VEC_BITS-1:0] src_b,
  input  logic [VEC_BITS-1:0] dst_in,
  input  logic [IDX_W-1:0]    index,
  output logic [VEC_BITS-1:0] result
);
  localparam int N   = VEC_BITS / EW;    // elements per vector
  localparam int LN  = $clog2(N);
  localparam int H   = N / 2;
  localparam int NB  = VEC_BITS / 8;     // bytes per vector
  localparam int NSL = NB / N;           // slide slices
  localparam int KW  = LN + 1;           // shuffle select width (mod 2N)
  localparam logic [EW-1:0] CTL_KILL = EW'(8'hC0);
  localparam logic [EW-1:0] CTL_SEL  = EW'(8'h3F);

  logic [EW-1:0] ea [N];
  logic [EW-1:0] eb [N];
  logic [EW-1:0] ed [N];
  logic [EW-1:0] er [N];
  logic [7:0]    sa_b [NB];
  logic [7:0]    sd_b [NB];
  logic [7:0]    so_b [NB];
  logic [KW-1:0] ksel [N];
  logic          kill [N];
  logic [LN-1:0] n_sel;

  assign n_sel = LN'(index % IDX_W'(N));

  always_comb begin
    for (int e = 0; e < N; e++) begin
      ea[e]   = src_a[e*EW +: EW];
      eb[e]   = src_b[e*EW +: EW];
      ed[e]   = dst_in[e*EW +: EW];
      kill[e] = |(ed[e] & CTL_KILL);
      ksel[e] = KW'((ed[e] & CTL_SEL) % EW'(2*N));
    end
    for (int b = 0; b < NB; b++) begin
      sa_b[b] = src_a[b*8 +: 8];
      sd_b[b] = dst_in[b*8 +: 8];
    end
  end

  // Slide: each slice joins A (low) with D (high) and takes N bytes at n.
  always_comb begin
    for (int s = 0; s < NSL; s++) begin
      for (int i = 0; i < N; i++) begin
        if (i + int'(n_sel) < N)
          so_b[s*N+i] = sa_b[s*N + i + int'(n_sel)];
        else
          so_b[s*N+i] = sd_b[s*N + i + int'(n_sel) - N];
      end
    end
  end

  always_comb begin
    for (int e = 0; e < N; e++) er[e] = '0;
    case (perm_op_e'(op))
      PERM_SPLAT: begin
        for (int e = 0; e < N; e++) er[e] = ea[n_sel];
      end
      PERM_PACK_EV: begin
        for (int i = 0; i < H; i++) begin
          er[i]   = eb[2*i];
          er[H+i] = ea[2*i];
        end
      end
      PERM_PACK_OD: begin
        for (int i = 0; i < H; i++) begin
          er[i]   = eb[2*i+1];
          er[H+i] = ea[2*i+1];
        end
      end
      PERM_ILV_LEFT: begin
        for (int i = 0; i < H; i++) begin
          er[2*i]   = eb[H+i];
          er[2*i+1] = ea[H+i];
        end
      end
      PERM_ILV_RIGHT: begin
        for (int i = 0; i < H; i++) begin
          er[2*i]   = eb[i];
          er[2*i+1] = ea[i];
        end
      end
      PERM_ILV_EVEN: begin
        for (int i = 0; i < H; i++) begin
          er[2*i]   = eb[2*i];
          er[2*i+1] = ea[2*i];
        end
      end
      PERM_ILV_ODD: begin
        for (int i = 0; i < H; i++) begin
          er[2*i]   = eb[2*i+1];
          er[2*i+1] = ea[2*i+1];
        end
      end
      PERM_SHUFFLE: begin
        for (int e = 0; e < N; e++) begin
          if (kill[e])
            er[e] = '0;
          else if (ksel[e][KW-1])
            er[e] = ea[ksel[e][LN-1:0]];
          else
            er[e] = eb[ksel[e][LN-1:0]];
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    result = '0;
    if (perm_op_e'(op) == PERM_SLIDE) begin
      for (int b = 0; b < NB; b++) result[b*8 +: 8] = so_b[b];
    end else begin
      for (int e = 0; e < N; e++) result[e*EW +: EW] = er[e];
    end
  end
endmodule

// File: rtl/vperm_out_stage.sv
`timescale 1ns/1ps
// Single result register with valid/ready on both sides.
module vperm_out_stage #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) out_data <= in_data;
    end
  end
endmodule

// File: rtl/vperm_unit.sv
`timescale 1ns/1ps
module vperm_unit
  import vperm_pkg::*;
#(
  parameter int VEC_BITS = VEC_W,
  parameter int FMT_BITS = FMT_W,
  parameter int MIN_EW   = BASE_EW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [OP_W-1:0]     op,
  input  logic [FMT_BITS-1:0] fmt,
  input  logic [VEC_BITS-1:0] src_a,
  input  logic [VEC_BITS-1:0] src_b,
  input  logic [VEC_BITS-1:0] dst_in,
  input  logic [IDX_W-1:0]    index,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [VEC_BITS-1:0] out_vec
);
  localparam int NFMT = 1 << FMT_BITS;

  logic [VEC_BITS-1:0] fmt_res [NFMT];
  logic [VEC_BITS-1:0] sel_res;

  for (genvar f = 0; f < NFMT; f++) begin : g_fmt
    vperm_fmt_engine #(
      .VEC_BITS (VEC_BITS),
      .EW       (MIN_EW << f)
    ) u_eng (
      .op     (op),
      .src_a  (src_a),
      .src_b  (src_b),
      .dst_in (dst_in),
      .index  (index),
      .result (fmt_res[f])
    );
  end

  assign sel_res = fmt_res[fmt];

  vperm_out_stage #(.W(VEC_BITS)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (sel_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_vec)
  );
endmodule

// File: rtl/vperm_unit_chk.sv
`timescale 1ns/1ps
module vperm_unit_chk
  import vperm_pkg::*;
#(
  parameter int VEC_BITS = VEC_W,
  parameter int FMT_BITS = FMT_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [OP_W-1:0]     op,
  input logic [FMT_BITS-1:0] fmt,
  input logic [VEC_BITS-1:0] dst_in,
  input logic                out_valid,
  input logic                out_ready,
  input logic [VEC_BITS-1:0] out_vec
);
  localparam int NB = VEC_BITS / 8;

  logic take;
  assign take = in_valid && in_ready;

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec)));

  p_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == 4'd0 && fmt == '0) |=> (out_vec == {NB{out_vec[7:0]}}));

  p_kill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == 4'd8 && dst_in == {NB{8'hC0}}) |=> (out_vec == '0));

  p_undef_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op > 4'd8) |=> (out_vec == '0));
endmodule

bind vperm_unit vperm_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op        (op),
  .fmt       (fmt),
  .dst_in    (dst_in),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_vec   (out_vec)
);

// File: tb/sim_vperm_unit.sv
`timescale 1ns/1ps
module sim_vperm_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [3:0]   op = '0;
  logic [1:0]   fmt = '0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic [127:0] dst_in = '0;
  logic [31:0]  index = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_vec;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;   // 125 MHz

  vperm_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .fmt(fmt), .src_a(src_a), .src_b(src_b), .dst_in(dst_in),
    .index(index), .out_valid(out_valid), .out_ready(out_ready),
    .out_vec(out_vec)
  );

  // ---------------- helpers ----------------
  task automatic rnd64(output logic [63:0] r);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    r = seed;
  endtask

  task automatic rnd128(output logic [127:0] v);
    logic [63:0] lo, hi;
    rnd64(lo);
    rnd64(hi);
    v = {hi, lo};
  endtask

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] getel(logic [127:0] v, int w, int i);
    logic [63:0] r = '0;
    for (int b = 0; b < w; b++) r[b] = v[i*w+b];
    return r;
  endfunction

  function automatic logic [127:0] putel(logic [127:0] v, int w, int i, logic [63:0] x);
    logic [127:0] r = v;
    for (int b = 0; b < w; b++) r[i*w+b] = x[b];
    return r;
  endfunction

  // Expected result, written from the requirement text.
  function automatic logic [127:0] model(logic [3:0] o, logic [1:0] f, logic [127:0] a,
                                         logic [127:0] b, logic [127:0] d, logic [31:0] ix);
    int w  = 8 << f;
    int ne = 128 / w;
    int h  = ne / 2;
    int n  = int'(ix % ne);
    logic [127:0] r = '0;
    case (o)
      4'd0: for (int e = 0; e < ne; e++) r = putel(r, w, e, getel(a, w, n));
      4'd1: begin
        for (int s = 0; s < 16 / ne; s++) begin
          for (int i = 0; i < ne; i++) begin
            int j = i + n;
            logic [7:0] by;
            if (j < ne) by = a[8*(s*ne+j) +: 8];
            else        by = d[8*(s*ne+j-ne) +: 8];
            r[8*(s*ne+i) +: 8] = by;
          end
        end
      end
      4'd2, 4'd3: begin
        int odd = (o == 4'd3) ? 1 : 0;
        for (int i = 0; i < h; i++) begin
          r = putel(r, w, i,     getel(b, w, 2*i+odd));
          r = putel(r, w, h + i, getel(a, w, 2*i+odd));
        end
      end
      4'd4, 4'd5: begin
        int base = (o == 4'd4) ? h : 0;
        for (int i = 0; i < h; i++) begin
          r = putel(r, w, 2*i,   getel(b, w, base+i));
          r = putel(r, w, 2*i+1, getel(a, w, base+i));
        end
      end
      4'd6, 4'd7: begin
        int odd = (o == 4'd7) ? 1 : 0;
        for (int i = 0; i < h; i++) begin
          r = putel(r, w, 2*i,   getel(b, w, 2*i+odd));
          r = putel(r, w, 2*i+1, getel(a, w, 2*i+odd));
        end
      end
      4'd8: begin
        for (int e = 0; e < ne; e++) begin
          logic [63:0] c = getel(d, w, e);
          int k = int'(c[5:0]) % (2*ne);
          if (c[7] || c[6])  r = putel(r, w, e, 64'd0);
          else if (k < ne)   r = putel(r, w, e, getel(b, w, k));
          else               r = putel(r, w, e, getel(a, w, k - ne));
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  // Issue one request with an idle consumer-ready output, then check it.
  task automatic run_op(input string tag, input logic [3:0] o, input logic [1:0] f,
                        input logic [127:0] a, input logic [127:0] b,
                        input logic [127:0] d, input logic [31:0] ix);
    @(negedge clk);
    op = o; fmt = f; src_a = a; src_b = b; dst_in = d; index = ix;
    out_ready = 1'b1;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R1 out_valid"}, {127'd0, out_valid}, 128'd1);
    check(tag, out_vec, model(o, f, a, b, d, ix));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    #1;
    check("R3 out_valid in reset", {127'd0, out_valid}, 128'd0);
    check("R3 in_ready in reset",  {127'd0, in_ready},  128'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_broadcast();
    logic [127:0] a, b, d;
    for (int i = 0; i < 16; i++) a[8*i +: 8] = 8'(i);
    run_op("R4 broadcast byte idx21", 4'd0, 2'd0, a, '0, '0, 32'd21);
    check("R4 broadcast literal", out_vec, {16{8'h05}});
    for (int i = 0; i < 8; i++) a[16*i +: 16] = 16'h1100 + 16'(i);
    run_op("R12 broadcast half idx9", 4'd0, 2'd1, a, '0, '0, 32'd9);
    check("R12 broadcast half literal", out_vec, {8{16'h1101}});
    for (int f = 0; f < 4; f++) begin
      rnd128(a); rnd128(b); rnd128(d);
      run_op("R4 broadcast big index", 4'd0, 2'(f), a, b, d, 32'hFFFF_FFF0 + 32'(f*7));
    end
  endtask

  task automatic t_slide();
    logic [127:0] a, b, d;
    for (int i = 0; i < 16; i++) begin
      a[8*i +: 8] = 8'(i);
      d[8*i +: 8] = 8'h10 + 8'(i);
    end
    run_op("R5 slide byte idx3", 4'd1, 2'd0, a, '0, d, 32'd3);
    check("R5 slide literal", out_vec, 128'h1211100f_0e0d0c0b_0a090807_06050403);
    for (int f = 0; f < 4; f++) begin
      for (int n = 0; n < 3; n++) begin
        rnd128(a); rnd128(b); rnd128(d);
        run_op("R5 slide per slice", 4'd1, 2'(f), a, b, d, 32'h8000_0000 + 32'(n*5+1));
      end
    end
  endtask

  task automatic t_pack();
    logic [127:0] a, b, d;
    for (int f = 0; f < 4; f++) begin
      rnd128(a); rnd128(b); rnd128(d);
      run_op("R6 pack even", 4'd2, 2'(f), a, b, d, 32'd0);
      run_op("R6 pack odd",  4'd3, 2'(f), a, b, d, 32'd0);
    end
  endtask

  task automatic t_ilv_lr();
    logic [127:0] a, b, d;
    for (int f = 0; f < 4; f++) begin
      rnd128(a); rnd128(b); rnd128(d);
      run_op("R7 interleave left",  4'd4, 2'(f), a, b, d, 32'd0);
      run_op("R7 interleave right", 4'd5, 2'(f), a, b, d, 32'd0);
    end
  endtask

  task automatic t_ilv_eo();
    logic [127:0] a, b, d;
    for (int i = 0; i < 4; i++) begin
      a[32*i +: 32] = 32'hA000_0000 + 32'(i);
      b[32*i +: 32] = 32'hB000_0000 + 32'(i);
    end
    run_op("R8 interleave even word", 4'd6, 2'd2, a, b, '0, 32'd0);
    check("R8 interleave even literal", out_vec,
          {32'hA000_0002, 32'hB000_0002, 32'hA000_0000, 32'hB000_0000});
    for (int f = 0; f < 4; f++) begin
      rnd128(a); rnd128(b); rnd128(d);
      run_op("R8 interleave even", 4'd6, 2'(f), a, b, d, 32'd0);
      run_op("R8 interleave odd",  4'd7, 2'(f), a, b, d, 32'd0);
    end
  endtask

  task automatic t_shuffle_sel();
    logic [127:0] a, b, d;
    for (int f = 0; f < 4; f++) begin
      rnd128(a); rnd128(b); rnd128(d);
      d = d & {16{8'h3F}};
      run_op("R9 shuffle select", 4'd8, 2'(f), a, b, d, 32'd0);
    end
    rnd128(a); rnd128(b);
    d = {64'h0000_0000_0000_0040, 64'h0000_0000_0000_0103};
    run_op("R9 shuffle dword high ctl bits", 4'd8, 2'd3, a, b, d, 32'd0);
    check("R10 shuffle dword literal", out_vec, {64'd0, a[127:64]});
  endtask

  task automatic t_shuffle_kill();
    logic [127:0] a, b, d;
    rnd128(a); rnd128(b);
    run_op("R10 shuffle all killed", 4'd8, 2'd0, a, b, {16{8'hC0}}, 32'd0);
    check("R10 shuffle all zero", out_vec, 128'd0);
    for (int f = 0; f < 4; f++) begin
      rnd128(a); rnd128(b); rnd128(d);
      run_op("R10 shuffle mixed kill", 4'd8, 2'(f), a, b, d, 32'd0);
    end
  endtask

  task automatic t_undefined();
    logic [127:0] a, b, d;
    for (int o = 9; o < 16; o++) begin
      rnd128(a); rnd128(b); rnd128(d);
      run_op("R11 undefined op", 4'(o), 2'(o % 4), a, b, d, 32'd7);
      check("R11 undefined op zero", out_vec, 128'd0);
    end
  endtask

  task automatic t_stall();
    logic [127:0] a1, b1, a2, b2;
    rnd128(a1); rnd128(b1); rnd128(a2); rnd128(b2);
    @(negedge clk);
    out_ready = 1'b0;
    op = 4'd5; fmt = 2'd0; src_a = a1; src_b = b1; dst_in = '0; index = '0;
    in_valid = 1'b1;
    @(negedge clk);
    check("R1 accepted first", {127'd0, out_valid}, 128'd1);
    op = 4'd4; fmt = 2'd1; src_a = a2; src_b = b2;
    #1;
    check("R2 in_ready low while stalled", {127'd0, in_ready}, 128'd0);
    @(negedge clk);
    check("R2 valid held", {127'd0, out_valid}, 128'd1);
    check("R2 data held", out_vec, model(4'd5, 2'd0, a1, b1, '0, '0));
    out_ready = 1'b1;
    #1;
    check("R1 in_ready when draining", {127'd0, in_ready}, 128'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 second after drain", out_vec, model(4'd4, 2'd1, a2, b2, '0, '0));
    @(negedge clk);
    check("R1 empty after drain", {127'd0, out_valid}, 128'd0);
  endtask

  initial begin
    t_reset();
    t_broadcast();
    t_slide();
    t_pack();
    t_ilv_lr();
    t_ilv_eo();
    t_shuffle_sel();
    t_shuffle_kill();
    t_undefined();
    t_stall();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule